// File: doc/BRIEF.md
# Shuffle-Exchange Processor-to-Memory Switch Fabric

This block joins eight requesting processors to eight memory modules through three columns of 2x2 exchange elements. Each element passes its two inputs either straight or crossed. A processor raises its request line together with a 3-bit memory number. The fabric then tries to reserve a route through every column. Some routes cannot be reserved, because an earlier path already holds a link or because another request wants the same element output in the same cycle. The fabric reports the outcome to each processor as a single-cycle win or loss pulse, always at the same fixed delay.

A reserved route stays in place for the whole transfer. The processor sends the memory address as the first word and then its data words. Flow control is a plain valid/ready pair, passed straight through the route. The memory side sees a marker on the first word of each route, so it can tell the address from the data. The route is freed when the processor lowers its request line. Retry decisions belong to the processors: a processor that loses must lower its request before it can compete again.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant`, `blocked`, `src_wrdy` and `dst_wvld` are all zero.
- R2: A request is taken on a rising edge where `req_vld[s]` is high and source s neither holds a route nor waits for a drop. It yields exactly one pulse, on `grant[s]` or on `blocked[s]` and never on both. The pulse is one cycle wide and is registered on the third rising edge, counting the taking edge as the first. Both outputs stay low on the edge before.
- R3: Routing follows the destination tag. Before column 0, and between columns, line index i moves to its left rotation (bits [1:0],[2] for three bits). Column k steers by destination bit (2-k): a 0 goes to the element's upper output, which is the even line, and a 1 goes to the lower output, the odd line. Eight requests that all name distinct memories along the identity pattern are all granted.
- R4: When both inputs of an element want the same output, the input on the even line wins and the other request is blocked. This can favour the higher-numbered source. Sources 1 and 2 both naming memory 5 give grant to 2. Source 0 to memory 0 against source 4 to memory 1 gives grant to 0, as does source 0 to memory 0 against source 2 to memory 1.
- R5: A link held by an existing route blocks any new request that needs it. A new request sharing no link with the held routes is granted.
- R6: A route is held until a rising edge samples its source's request low. That edge frees it, and a request taken on any later edge may use its links.
- R7: A source that was blocked or that holds a route makes no new request, and gets no pulse, until its request line has been sampled low on at least one edge.
- R8: For a held route from s to d, `dst_wvld[d]` and `dst_word[d]` follow `src_wvld[s]` and `src_word[s]`, and `src_wrdy[s]` follows `dst_wrdy[d]`. A memory with no route sees `dst_wvld` low, and a source with no route sees `src_wrdy` low.
- R9: `dst_first[d]` is high from the moment a route to d is reserved until the first handshake on that route, which carries the address. After that handshake it is low for the data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 8 | Route request per source, held for the whole transfer |
| req_dst | input | 8x3 | Requested memory number per source |
| grant | output | 8 | One-cycle pulse: route reserved |
| blocked | output | 8 | One-cycle pulse: route refused |
| src_wvld | input | 8 | Word valid from each source |
| src_word | input | 8x32 | Word from each source (address first, then data) |
| src_wrdy | output | 8 | Ready returned to each source through its route |
| dst_wvld | output | 8 | Word valid toward each memory |
| dst_word | output | 8x32 | Word toward each memory |
| dst_first | output | 8 | Marks the address word of the route to each memory |
| dst_wrdy | input | 8 | Ready from each memory |

## Verification
Several properties are checked on every cycle. Grant and block pulses match the requests taken three edges earlier and are never both set. No line leaving a column coincides with a held link. Each memory has at most one route holder, and a surviving line at the last column sits on its own tag. A route is gone one edge after its request drops, ready only reaches a source that holds a route, and the first-word marker clears after the address handshake. Only the directed scenarios can show which requests should win: the positional priority that lets source 2 beat source 1, the stage at which each collision happens, the refusal to retry while the request stays high, and the exact cycle at which each pulse appears.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Left rotation of an lg-bit line index (perfect shuffle).
  function automatic int unsigned rotl_idx(input int unsigned x, input int unsigned lg);
    int unsigned m;
    m = (32'd1 << lg) - 32'd1;
    return ((x << 1) | (x >> (lg - 32'd1))) & m;
  endfunction

  // Line index leaving column stg for a route from src to dst.
  function automatic int unsigned stage_link(input int unsigned src, input int unsigned dst,
                                             input int unsigned stg, input int unsigned lg);
    int unsigned line;
    line = rotl_idx(src, lg);
    for (int unsigned k = 0; k < 16; k++) begin
      if (k < lg && k <= stg) begin
        line = (line & ~32'd1) | ((dst >> (lg - 32'd1 - k)) & 32'd1);
        if (k != stg) line = rotl_idx(line, lg);
      end
    end
    return line;
  endfunction

endpackage

// File: rtl/omega_sw.sv
module omega_sw #(
  parameter int unsigned AW    = 3,
  parameter int unsigned STEER = 2
) (
  input  logic          a_vld,
  input  logic [AW-1:0] a_src,
  input  logic [AW-1:0] a_dst,
  input  logic          b_vld,
  input  logic [AW-1:0] b_src,
  input  logic [AW-1:0] b_dst,
  input  logic          lock_up,
  input  logic          lock_dn,
  output logic          up_vld,
  output logic [AW-1:0] up_src,
  output logic [AW-1:0] up_dst,
  output logic          dn_vld,
  output logic [AW-1:0] dn_src,
  output logic [AW-1:0] dn_dst
);
  logic a_up, a_dn, b_up, b_dn;

  assign a_up = a_vld & ~a_dst[STEER];
  assign a_dn = a_vld &  a_dst[STEER];
  assign b_up = b_vld & ~b_dst[STEER];
  assign b_dn = b_vld &  b_dst[STEER];

  // Upper input (even line) has priority on either output.
  assign up_vld = ~lock_up & (a_up | b_up);
  assign up_src = a_up ? a_src : b_src;
  assign up_dst = a_up ? a_dst : b_dst;

  assign dn_vld = ~lock_dn & (a_dn | b_dn);
  assign dn_src = a_dn ? a_src : b_src;
  assign dn_dst = a_dn ? a_dst : b_dst;
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter  int unsigned AW  = 3,
  parameter  int unsigned STG = 0,
  localparam int unsigned N   = 1 << AW
) (
  input  logic [N-1:0]         in_vld,
  input  logic [N-1:0][AW-1:0] in_src,
  input  logic [N-1:0][AW-1:0] in_dst,
  input  logic [N-1:0]         lock,
  output logic [N-1:0]         out_vld,
  output logic [N-1:0][AW-1:0] out_src,
  output logic [N-1:0][AW-1:0] out_dst
);
  logic [N-1:0]         sh_vld;
  logic [N-1:0][AW-1:0] sh_src;
  logic [N-1:0][AW-1:0] sh_dst;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int unsigned T = omega_pkg::rotl_idx(i, AW);
    assign sh_vld[T] = in_vld[i];
    assign sh_src[T] = in_src[i];
    assign sh_dst[T] = in_dst[i];
  end

  for (genvar w = 0; w < N / 2; w++) begin : g_sw
    omega_sw #(.AW(AW), .STEER(AW - 1 - STG)) u_sw (
      .a_vld   (sh_vld[2*w]),
      .a_src   (sh_src[2*w]),
      .a_dst   (sh_dst[2*w]),
      .b_vld   (sh_vld[2*w+1]),
      .b_src   (sh_src[2*w+1]),
      .b_dst   (sh_dst[2*w+1]),
      .lock_up (lock[2*w]),
      .lock_dn (lock[2*w+1]),
      .up_vld  (out_vld[2*w]),
      .up_src  (out_src[2*w]),
      .up_dst  (out_dst[2*w]),
      .dn_vld  (out_vld[2*w+1]),
      .dn_src  (out_src[2*w+1]),
      .dn_dst  (out_dst[2*w+1])
    );
  end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter  int unsigned AW = 3,
  localparam int unsigned N  = 1 << AW
) (
  input  logic [N-1:0]          req_take,
  input  logic [N-1:0][AW-1:0]  req_dst,
  input  logic [AW-1:0][N-1:0]  link_used,
  output logic [N-1:0]          won,
  output logic [AW-1:0][N-1:0]  stage_vld,
  output logic [N-1:0][AW-1:0]  fin_dst
);
  for (genvar k = 0; k < AW; k++) begin : g_stage
    logic [N-1:0]         i_vld, o_vld;
    logic [N-1:0][AW-1:0] i_src, i_dst, o_src, o_dst;

    if (k == 0) begin : g_head
      assign i_vld = req_take;
      assign i_dst = req_dst;
      for (genvar s = 0; s < N; s++) begin : g_id
        assign i_src[s] = AW'(s);
      end
    end else begin : g_link
      assign i_vld = g_stage[k-1].o_vld;
      assign i_src = g_stage[k-1].o_src;
      assign i_dst = g_stage[k-1].o_dst;
    end

    omega_stage #(.AW(AW), .STG(k)) u_stage (
      .in_vld  (i_vld),
      .in_src  (i_src),
      .in_dst  (i_dst),
      .lock    (link_used[k]),
      .out_vld (o_vld),
      .out_src (o_src),
      .out_dst (o_dst)
    );

    assign stage_vld[k] = o_vld;
  end

  logic [N-1:0]         fin_vld;
  logic [N-1:0][AW-1:0] fin_src;
  assign fin_vld = g_stage[AW-1].o_vld;
  assign fin_src = g_stage[AW-1].o_src;
  assign fin_dst = g_stage[AW-1].o_dst;

  always_comb begin
    won = '0;
    for (int j = 0; j < N; j++) begin
      if (fin_vld[j]) won[fin_src[j]] = 1'b1;
    end
  end
endmodule

// File: rtl/omega_hold.sv
module omega_hold #(
  parameter  int unsigned AW = 3,
  parameter  int unsigned DW = 32,
  localparam int unsigned N  = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_vld,
  input  logic [N-1:0][AW-1:0] req_dst,
  input  logic [N-1:0]         won,
  input  logic [N-1:0]         src_wvld,
  input  logic [N-1:0][DW-1:0] src_word,
  input  logic [N-1:0]         dst_wrdy,
  output logic [N-1:0]         req_take,
  output logic [N-1:0]         hold,
  output logic [N-1:0][AW-1:0] held_dst,
  output logic [AW-1:0][N-1:0] link_used,
  output logic [N-1:0]         src_wrdy,
  output logic [N-1:0]         dst_wvld,
  output logic [N-1:0][DW-1:0] dst_word,
  output logic [N-1:0]         dst_first
);
  logic [N-1:0]         own_q, stall_q, first_q;
  logic [N-1:0][AW-1:0] dst_q;

  assign req_take = req_vld & ~own_q & ~stall_q;
  assign hold     = own_q;
  assign held_dst = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      stall_q <= '0;
      first_q <= '0;
      dst_q   <= '0;
    end else begin
      for (int s = 0; s < N; s++) begin
        if (req_take[s]) begin
          own_q[s]   <= won[s];
          stall_q[s] <= ~won[s];
          first_q[s] <= won[s];
          dst_q[s]   <= req_dst[s];
        end else begin
          if (!req_vld[s]) begin
            own_q[s]   <= 1'b0;
            stall_q[s] <= 1'b0;
          end
          if (src_wvld[s] && src_wrdy[s]) first_q[s] <= 1'b0;
        end
      end
    end
  end

  // Links occupied by held routes, per column.
  always_comb begin
    logic [AW-1:0] ln;
    link_used = '0;
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k < AW; k++) begin
        ln = AW'(omega_pkg::stage_link(32'(s), 32'(dst_q[s]), 32'(k), AW));
        if (own_q[s]) link_used[k][ln] = 1'b1;
      end
    end
  end

  // Word forwarding over held routes.
  always_comb begin
    dst_wvld  = '0;
    dst_word  = '0;
    dst_first = '0;
    for (int s = 0; s < N; s++) begin
      src_wrdy[s] = own_q[s] & dst_wrdy[dst_q[s]];
      if (own_q[s]) begin
        dst_wvld[dst_q[s]]  = src_wvld[s];
        dst_word[dst_q[s]]  = src_word[s];
        dst_first[dst_q[s]] = first_q[s];
      end
    end
  end
endmodule

// File: rtl/omega_resp.sv
module omega_resp #(
  parameter  int unsigned AW  = 3,
  parameter  int unsigned LAT = 3,
  localparam int unsigned N   = 1 << AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_take,
  input  logic [N-1:0] won,
  output logic [N-1:0] grant,
  output logic [N-1:0] blocked
);
  logic [LAT-1:0][N-1:0] g_pipe, b_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_pipe <= '0;
      b_pipe <= '0;
    end else begin
      g_pipe[0] <= req_take & won;
      b_pipe[0] <= req_take & ~won;
      for (int i = 1; i < LAT; i++) begin
        g_pipe[i] <= g_pipe[i-1];
        b_pipe[i] <= b_pipe[i-1];
      end
    end
  end

  assign grant   = g_pipe[LAT-1];
  assign blocked = b_pipe[LAT-1];
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter  int unsigned ADDR_W   = 3,
  parameter  int unsigned DATA_W   = 32,
  parameter  int unsigned RESP_LAT = 3,
  localparam int unsigned N        = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             req_vld,
  input  logic [N-1:0][ADDR_W-1:0] req_dst,
  output logic [N-1:0]             grant,
  output logic [N-1:0]             blocked,
  input  logic [N-1:0]             src_wvld,
  input  logic [N-1:0][DATA_W-1:0] src_word,
  output logic [N-1:0]             src_wrdy,
  output logic [N-1:0]             dst_wvld,
  output logic [N-1:0][DATA_W-1:0] dst_word,
  output logic [N-1:0]             dst_first,
  input  logic [N-1:0]             dst_wrdy
);
  // Named internal events, observed by the bound checker.
  logic [N-1:0]             req_take;
  logic [N-1:0]             won;
  logic [N-1:0]             hold;
  logic [N-1:0][ADDR_W-1:0] held_dst;
  logic [ADDR_W-1:0][N-1:0] link_used;
  logic [ADDR_W-1:0][N-1:0] stage_vld;
  logic [N-1:0][ADDR_W-1:0] fin_dst;

  omega_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_dst   (req_dst),
    .won       (won),
    .src_wvld  (src_wvld),
    .src_word  (src_word),
    .dst_wrdy  (dst_wrdy),
    .req_take  (req_take),
    .hold      (hold),
    .held_dst  (held_dst),
    .link_used (link_used),
    .src_wrdy  (src_wrdy),
    .dst_wvld  (dst_wvld),
    .dst_word  (dst_word),
    .dst_first (dst_first)
  );

  omega_fabric #(.AW(ADDR_W)) u_fabric (
    .req_take  (req_take),
    .req_dst   (req_dst),
    .link_used (link_used),
    .won       (won),
    .stage_vld (stage_vld),
    .fin_dst   (fin_dst)
  );

  omega_resp #(.AW(ADDR_W), .LAT(RESP_LAT)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_take (req_take),
    .won      (won),
    .grant    (grant),
    .blocked  (blocked)
  );
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter  int unsigned AW  = 3,
  parameter  int unsigned LAT = 3,
  localparam int unsigned N   = 1 << AW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req_vld,
  input logic [N-1:0]         req_take,
  input logic [N-1:0]         hold,
  input logic [N-1:0][AW-1:0] held_dst,
  input logic [AW-1:0][N-1:0] link_used,
  input logic [AW-1:0][N-1:0] stage_vld,
  input logic [N-1:0][AW-1:0] fin_dst,
  input logic [N-1:0]         grant,
  input logic [N-1:0]         blocked,
  input logic [N-1:0]         src_wrdy,
  input logic [N-1:0]         dst_wvld,
  input logic [N-1:0]         dst_wrdy,
  input logic [N-1:0]         dst_first
);
  // Shadow delay of taken requests, counted independently.
  logic [LAT-1:0][N-1:0] shadow;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else begin
      shadow[0] <= req_take;
      for (int i = 1; i < LAT; i++) shadow[i] <= shadow[i-1];
    end
  end

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & blocked) == '0);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant | blocked) == shadow[LAT-1]);

  assert_ready_needs_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wrdy & ~hold) == '0);

  for (genvar k = 0; k < AW; k++) begin : g_col
    assert_lock_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld[k] & link_used[k]) == '0);
  end

  for (genvar j = 0; j < N; j++) begin : g_dst
    logic [N-1:0] to_j;
    always_comb begin
      for (int s = 0; s < N; s++) to_j[s] = hold[s] && (held_dst[s] == AW'(j));
    end

    assert_single_holder_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(to_j) <= 1);

    assert_tag_reaches_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stage_vld[AW-1][j] |-> (fin_dst[j] == AW'(j)));

    assert_first_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_wvld[j] && dst_wrdy[j] && dst_first[j]) |=> !dst_first[j]);
  end

  for (genvar s = 0; s < N; s++) begin : g_src
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold[s] && !req_vld[s]) |=> !hold[s]);
  end
endmodule

bind omega_net omega_net_chk #(.AW(ADDR_W), .LAT(RESP_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_take  (req_take),
  .hold      (hold),
  .held_dst  (held_dst),
  .link_used (link_used),
  .stage_vld (stage_vld),
  .fin_dst   (fin_dst),
  .grant     (grant),
  .blocked   (blocked),
  .src_wrdy  (src_wrdy),
  .dst_wvld  (dst_wvld),
  .dst_wrdy  (dst_wrdy),
  .dst_first (dst_first)
);

// File: tb/test_omega_net.sv
module test_omega_net;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       req_vld;
  logic [7:0][2:0]  req_dst;
  logic [7:0]       grant, blocked;
  logic [7:0]       src_wvld;
  logic [7:0][31:0] src_word;
  logic [7:0]       src_wrdy;
  logic [7:0]       dst_wvld;
  logic [7:0][31:0] dst_word;
  logic [7:0]       dst_first;
  logic [7:0]       dst_wrdy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omega_net i_omega_net (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_dst   (req_dst),
    .grant     (grant),
    .blocked   (blocked),
    .src_wvld  (src_wvld),
    .src_word  (src_word),
    .src_wrdy  (src_wrdy),
    .dst_wvld  (dst_wvld),
    .dst_word  (dst_word),
    .dst_first (dst_first),
    .dst_wrdy  (dst_wrdy)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Raise requests at a falling edge; check timing and outcome.
  task automatic issue(input logic [7:0] raise, input logic [7:0][2:0] dsts,
                       input logic [7:0] eg, input logic [7:0] eb, input string req);
    for (int s = 0; s < 8; s++) begin
      if (raise[s]) begin
        req_dst[s] = dsts[s];
        req_vld[s] = 1'b1;
      end
    end
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2", "no pulse before third edge", 64'({grant, blocked}), 64'd0);
    @(posedge clk); @(negedge clk);
    chk(req, "grant", 64'(grant), 64'(eg));
    chk(req, "blocked", 64'(blocked), 64'(eb));
    @(posedge clk); @(negedge clk);
    chk("R2", "pulse one cycle wide", 64'({grant, blocked}), 64'd0);
  endtask

  task automatic drop(input logic [7:0] m);
    req_vld = req_vld & ~m;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_vld = '0; req_dst = '0; src_wvld = '0; src_word = '0; dst_wrdy = '0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", 64'({grant, blocked, src_wrdy, dst_wvld}), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "outputs after reset", 64'({grant, blocked, src_wrdy, dst_wvld}), 64'd0);
  endtask

  task automatic t_identity;
    logic [7:0][2:0] d;
    for (int s = 0; s < 8; s++) d[s] = 3'(s);
    issue(8'hFF, d, 8'hFF, 8'h00, "R3 identity");
    drop(8'hFF);
  endtask

  task automatic t_conflicts;
    logic [7:0][2:0] d;
    d = '0; d[0] = 3'd0; d[4] = 3'd1;
    issue(8'h11, d, 8'h01, 8'h10, "R4 column0");
    drop(8'h11);
    d = '0; d[0] = 3'd0; d[2] = 3'd1;
    issue(8'h05, d, 8'h01, 8'h04, "R4 column1");
    drop(8'h05);
    d = '0; d[1] = 3'd5; d[2] = 3'd5;
    issue(8'h06, d, 8'h04, 8'h02, "R4 column2 even line wins");
    drop(8'h06);
  endtask

  task automatic t_lock;
    logic [7:0][2:0] d;
    d = '0; d[3] = 3'd6;
    issue(8'h08, d, 8'h08, 8'h00, "R5 first route");
    d = '0; d[7] = 3'd2;
    issue(8'h80, d, 8'h80, 8'h00, "R5 disjoint route");
    d = '0; d[5] = 3'd7;
    issue(8'h20, d, 8'h00, 8'h20, "R5 held link");
    drop(8'h28);
    issue(8'h20, d, 8'h20, 8'h00, "R6 freed link");
    drop(8'hA0);
  endtask

  task automatic t_no_retry;
    logic [7:0][2:0] d;
    d = '0; d[0] = 3'd0; d[4] = 3'd1;
    issue(8'h11, d, 8'h01, 8'h10, "R7 setup");
    drop(8'h01);
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R7", "blocked source stays silent", 64'({grant, blocked}), 64'd0);
    end
    drop(8'h10);
    issue(8'h10, d, 8'h10, 8'h00, "R7 retry after drop");
    drop(8'h10);
  endtask

  task automatic t_data;
    logic [7:0][2:0] d;
    d = '0; d[2] = 3'd5;
    issue(8'h04, d, 8'h04, 8'h00, "R8 route 2 to 5");
    src_wvld[2] = 1'b1; src_word[2] = 32'hA5A5_0040; dst_wrdy = '0;
    #1;
    chk("R8", "dst valid map", 64'(dst_wvld), 64'h20);
    chk("R8", "dst word", 64'(dst_word[5]), 64'hA5A5_0040);
    chk("R9", "address marker", 64'(dst_first[5]), 64'd1);
    chk("R8", "ready held low", 64'(src_wrdy), 64'd0);
    dst_wrdy[5] = 1'b1;
    #1;
    chk("R8", "ready passed back", 64'(src_wrdy), 64'h04);
    @(posedge clk); @(negedge clk);
    src_word[2] = 32'h1234_5678;
    #1;
    chk("R9", "data marker low", 64'(dst_first[5]), 64'd0);
    chk("R8", "data word", 64'(dst_word[5]), 64'h1234_5678);
    src_wvld[2] = 1'b0; dst_wrdy = '0;
    drop(8'h04);
    src_wvld[2] = 1'b1;
    #1;
    chk("R8", "no valid without route", 64'(dst_wvld), 64'd0);
    src_wvld[2] = 1'b0;
  endtask

  initial begin
    t_reset;
    t_identity;
    t_conflicts;
    t_lock;
    t_no_retry;
    t_data;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule